// File: doc/BRIEF.md
# Timer Output Compare Channel Array

This block pairs a 16-bit up-counting timebase with four independent compare channels. Each channel holds a 16-bit compare value and a small configuration byte. When an enabled channel's value equals the running count in a cycle where the timebase advances, a compare event fires. The event latches the channel's sticky flag, drives the channel's output pin by a chosen action (set, clear, toggle or none), and can send the shared timebase back to zero.

Software reaches the block through a byte-wide write port. Compare values are loaded low byte first into a holding byte, and the high-byte write moves the whole 16-bit value in at once, so the comparator never sees a half-updated value. Flags are cleared by writing ones. Interrupt requests are the flags gated by each channel's interrupt enable.

Top module: `tmr_cmp_array`

## Requirements
- R1: A channel whose enable bit is 0 produces no compare events: its flag stays 0 and its output pin keeps its value.
- R2: A compare event occurs on a clock edge where `cnt_en` is 1, the channel is enabled and all 16 bits of its compare value equal `count`. Flag and pin change on that same edge.
- R3: Every compare event sets the channel's sticky flag (`cmp_flag`). `cmp_irq[i]` is 1 exactly when flag i and the channel's interrupt-enable bit are both 1.
- R4: When a channel with its clear-on-match bit set has an event, `count` is 0000h after that edge and counts 1, 2, ... on the following enabled edges.
- R5: Pin action codes: 3'b000 no change, 3'b001 drive 1, 3'b010 drive 0, 3'b011 invert; other codes leave the pin unchanged. The pin changes only on a compare event.
- R6: The pin action takes place whether the channel's interrupt enable is 0 or 1.
- R7: After reset all four `cmp_out` bits are 1, all flags and requests are 0, `count` is 0, and compare values and configuration bytes are 0.
- R8: A compare value rewritten after an event takes effect at once, so one channel can produce several events within one timer period.
- R9: A write to a channel's low byte changes only a holding byte; the active 16-bit compare value is replaced by {high byte, holding byte} on the edge of the high-byte write.
- R10: Writing data with bit i set to the flag-clear address clears flag i. If an event on channel i and such a clear fall on the same edge, the flag ends at 1.
- R11: When several clear-on-match channels have events on the same edge, `count` is 0 once and then counts up normally; every matching channel sets its flag and performs its pin action.
- R12: `count` advances by one on each edge with `cnt_en` at 1, holds when `cnt_en` is 0, and wraps from FFFFh to 0000h.
- R13: Write map (`wr_addr` = channel*4 + select): select 0 low byte, 1 high byte, 2 configuration; address 3 is the flag-clear register. Configuration bits: bit 0 compare enable, bit 1 clear-on-match, bit 2 interrupt enable, bits 5:3 pin action code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Timebase advance enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| count | output | 16 | Current timebase value |
| cmp_flag | output | 4 | Sticky compare flags, one per channel |
| cmp_irq | output | 4 | Interrupt requests, one per channel |
| cmp_out | output | 4 | Compare output pins, one per channel |

## Verification
The hardest situation to reach from the ports is an event landing on the very edge of a flag-clear write, since the event edge depends on the running count. The bench makes it reachable by holding `cnt_en` low while configuring, so the count is known exactly, then raising `cnt_en` and strobing the clear write on the same cycle with a compare value of zero. The same held-count technique places two simultaneous clearing matches and an atomic compare reload exactly where the checks expect them.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

  typedef enum logic [2:0] {
    ACT_NONE = 3'b000,
    ACT_SET  = 3'b001,
    ACT_CLR  = 3'b010,
    ACT_TOG  = 3'b011
  } act_e;

  localparam int SEL_LO   = 0;
  localparam int SEL_HI   = 1;
  localparam int SEL_CFG  = 2;
  localparam int SEL_FLAG = 3;
  localparam int SEL_W    = 2;

  // Pin value after a compare event with the given action code.
  function automatic logic pin_next(input logic [2:0] mode, input logic cur);
    case (mode)
      ACT_SET: pin_next = 1'b1;
      ACT_CLR: pin_next = 1'b0;
      ACT_TOG: pin_next = ~cur;
      default: pin_next = cur;
    endcase
  endfunction

endpackage

// File: rtl/tcmp_wr_decode.sv
module tcmp_wr_decode #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 4
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [NUM_CH-1:0] lo_we,
  output logic [NUM_CH-1:0] hi_we,
  output logic [NUM_CH-1:0] cfg_we,
  output logic              flag_we
);
  import tcmp_pkg::*;

  localparam int CH_W = ADDR_W - SEL_W;

  logic [SEL_W-1:0] sel;
  logic [CH_W-1:0]  ch;

  assign sel = wr_addr[SEL_W-1:0];
  assign ch  = wr_addr[ADDR_W-1:SEL_W];

  assign flag_we = wr_en && (ch == '0) && (sel == SEL_W'(SEL_FLAG));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    logic hit;
    assign hit      = wr_en && (ch == CH_W'(i));
    assign lo_we[i]  = hit && (sel == SEL_W'(SEL_LO));
    assign hi_we[i]  = hit && (sel == SEL_W'(SEL_HI));
    assign cfg_we[i] = hit && (sel == SEL_W'(SEL_CFG));
  end

endmodule

// File: rtl/tcmp_timebase.sv
module tcmp_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             any_clr,
  output logic [CNT_W-1:0] count
);

  // Next timebase value: clearing match beats increment; wrap is natural.
  function automatic logic [CNT_W-1:0] count_next(
    input logic [CNT_W-1:0] cur, input logic en, input logic clr);
    if (!en)      count_next = cur;
    else if (clr) count_next = '0;
    else          count_next = cur + CNT_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_next(count, cnt_en, any_clr);
  end

  assert_ctc_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && any_clr) |=> (count == '0));

  assert_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !any_clr) |=> (count == CNT_W'($past(count) + 1'b1)));

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(count));

endmodule

// File: rtl/tcmp_channel.sv
module tcmp_channel #(
  parameter int DATA_W = 8,
  parameter int CH_IDX = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cnt_en,
  input  logic [2*DATA_W-1:0] count,
  input  logic                lo_we,
  input  logic                hi_we,
  input  logic                cfg_we,
  input  logic                flag_we,
  input  logic [DATA_W-1:0]   wr_data,
  output logic                evt,
  output logic                clr_req,
  output logic                flag,
  output logic                irq,
  output logic                pin
);
  import tcmp_pkg::*;

  localparam int CNT_W = 2 * DATA_W;

  logic [DATA_W-1:0] shadow_lo;
  logic [CNT_W-1:0]  cmp_val;
  logic              en_q, ctc_q, ien_q;
  logic [2:0]        mode_q;
  logic              flag_clr;

  assign flag_clr = flag_we && wr_data[CH_IDX];

  // Holding byte and atomic 16-bit reload.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_lo <= '0;
      cmp_val   <= '0;
    end else begin
      if (lo_we) shadow_lo <= wr_data;
      if (hi_we) cmp_val   <= {wr_data, shadow_lo};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ctc_q  <= 1'b0;
      ien_q  <= 1'b0;
      mode_q <= ACT_NONE;
    end else if (cfg_we) begin
      en_q   <= wr_data[0];
      ctc_q  <= wr_data[1];
      ien_q  <= wr_data[2];
      mode_q <= wr_data[5:3];
    end
  end

  assign evt     = en_q && cnt_en && (count == cmp_val);
  assign clr_req = evt && ctc_q;

  // Sticky flag: a same-edge event overrides the clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (evt)      flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end

  assign irq = flag && ien_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pin <= 1'b1;
    else if (evt) pin <= pin_next(mode_q, pin);
  end

  assert_evt_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag);

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag);

  assert_pin_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && mode_q == ACT_SET) |=> pin);

  assert_pin_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && mode_q == ACT_CLR) |=> !pin);

  assert_pin_tog_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && mode_q == ACT_TOG) |=> (pin != $past(pin)));

  assert_pin_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> $stable(pin));

  assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !flag) |=> !flag);

endmodule

// File: rtl/tmr_cmp_array.sv
module tmr_cmp_array #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cnt_en,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [2*DATA_W-1:0] count,
  output logic [NUM_CH-1:0]   cmp_flag,
  output logic [NUM_CH-1:0]   cmp_irq,
  output logic [NUM_CH-1:0]   cmp_out
);

  localparam int CNT_W = 2 * DATA_W;

  logic [NUM_CH-1:0] lo_we, hi_we, cfg_we;
  logic              flag_we;
  logic [NUM_CH-1:0] cmp_evt;
  logic [NUM_CH-1:0] clr_req;
  logic              any_clr;

  tcmp_wr_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .lo_we   (lo_we),
    .hi_we   (hi_we),
    .cfg_we  (cfg_we),
    .flag_we (flag_we)
  );

  assign any_clr = |clr_req;

  tcmp_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_en  (cnt_en),
    .any_clr (any_clr),
    .count   (count)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    tcmp_channel #(.DATA_W(DATA_W), .CH_IDX(i)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt_en  (cnt_en),
      .count   (count),
      .lo_we   (lo_we[i]),
      .hi_we   (hi_we[i]),
      .cfg_we  (cfg_we[i]),
      .flag_we (flag_we),
      .wr_data (wr_data),
      .evt     (cmp_evt[i]),
      .clr_req (clr_req[i]),
      .flag    (cmp_flag[i]),
      .irq     (cmp_irq[i]),
      .pin     (cmp_out[i])
    );
  end

  assert_irq_needs_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> ((cmp_irq & ~cmp_flag) == '0));

  assert_multi_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(clr_req) > 1) |=> (count == '0) && ((cmp_flag & $past(clr_req)) == $past(clr_req)));

endmodule

// File: tb/tmr_cmp_array_bench.sv
module tmr_cmp_array_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] count;
  logic [3:0]  cmp_flag, cmp_irq, cmp_out;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  tmr_cmp_array u_tmr_cmp_array (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .count(count),
    .cmp_flag(cmp_flag), .cmp_irq(cmp_irq), .cmp_out(cmp_out)
  );

  localparam logic [2:0] M_NONE = 3'b000, M_SET = 3'b001, M_CLR = 3'b010, M_TOG = 3'b011;

  function automatic logic [7:0] cfgb(logic en, logic ctc, logic ien, logic [2:0] mode);
    return {2'b00, mode, ien, ctc, en};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cnt_en = 1'b0; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(int addr, logic [7:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = addr[3:0]; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_cmp(int ch, logic [15:0] v);
    wr(ch*4 + 0, v[7:0]);
    wr(ch*4 + 1, v[15:8]);
  endtask

  task automatic run(int n);
    @(negedge clk);
    cnt_en = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R7 cmp_out", cmp_out, 4'hF);
    chk("R7 cmp_flag", cmp_flag, 4'h0);
    chk("R7 cmp_irq", cmp_irq, 4'h0);
    chk("R7 count", count, 16'h0);
  endtask

  task automatic t_clear_no_irq();
    do_reset();
    set_cmp(0, 16'd5);
    wr(2, cfgb(1, 0, 0, M_CLR));
    run(5);
    chk("R2 no early event", cmp_out[0], 1'b1);
    run(1);
    chk("R6 pin action with irq off", cmp_out[0], 1'b0);
    chk("R3 flag set", cmp_flag[0], 1'b1);
    chk("R3 irq gated off", cmp_irq[0], 1'b0);
  endtask

  task automatic t_toggle_ctc();
    do_reset();
    set_cmp(1, 16'd3);
    wr(6, cfgb(1, 1, 1, M_TOG));
    run(4);
    chk("R5 toggle", cmp_out[1], 1'b0);
    chk("R3 irq enabled", cmp_irq[1], 1'b1);
    chk("R4 count cleared", count, 16'h0);
    run(1);
    chk("R4 restarts", count, 16'h1);
    run(3);
    chk("R5 toggle back", cmp_out[1], 1'b1);
    chk("R4 cleared again", count, 16'h0);
  endtask

  task automatic t_disabled();
    do_reset();
    set_cmp(2, 16'd2);
    wr(10, cfgb(0, 1, 1, M_CLR));
    run(5);
    chk("R1 pin unchanged", cmp_out[2], 1'b1);
    chk("R1 flag clear", cmp_flag[2], 1'b0);
    chk("R1 no timer clear", count, 16'd5);
  endtask

  task automatic t_shadow();
    do_reset();
    set_cmp(3, 16'd7);
    wr(12, 8'd2);
    wr(14, cfgb(1, 0, 0, M_CLR));
    run(3);
    chk("R9 low byte alone no effect", cmp_out[3], 1'b1);
    run(5);
    chk("R9 old value still active", cmp_out[3], 1'b0);
    do_reset();
    set_cmp(3, 16'h0102);
    wr(14, cfgb(1, 0, 0, M_SET));
    wr(14, cfgb(1, 0, 0, M_CLR));
    run(258);
    chk("R2 low byte match only", cmp_flag[3], 1'b0);
    run(1);
    chk("R2 full 16-bit match", cmp_flag[3], 1'b1);
    chk("R13 channel 3 pin", cmp_out, 4'h7);
  endtask

  task automatic t_flag_clear();
    do_reset();
    wr(2, cfgb(1, 0, 0, M_NONE));
    run(1);
    chk("R10 flag set", cmp_flag, 4'h1);
    chk("R5 action none", cmp_out[0], 1'b1);
    wr(3, 8'h01);
    chk("R10 write-one clears", cmp_flag[0], 1'b0);
    @(negedge clk);
    cnt_en = 1'b0;
    wr(3, 8'h00);
    do_reset();
    wr(2, cfgb(1, 0, 0, M_NONE));
    @(negedge clk);
    cnt_en = 1'b1; wr_en = 1'b1; wr_addr = 4'd3; wr_data = 8'h01;
    @(negedge clk);
    cnt_en = 1'b0; wr_en = 1'b0;
    chk("R10 event wins over clear", cmp_flag[0], 1'b1);
  endtask

  task automatic t_multi_ctc();
    do_reset();
    set_cmp(0, 16'd4);
    set_cmp(1, 16'd4);
    wr(2, cfgb(1, 1, 0, M_CLR));
    wr(6, cfgb(1, 1, 0, M_SET));
    run(5);
    chk("R11 count cleared", count, 16'h0);
    chk("R11 both flags", cmp_flag, 4'h3);
    chk("R11 both actions", cmp_out, 4'hE);
    run(1);
    chk("R11 single clear", count, 16'h1);
  endtask

  task automatic t_rewrite();
    do_reset();
    set_cmp(0, 16'd3);
    wr(2, cfgb(1, 0, 0, M_TOG));
    run(4);
    chk("R8 first event", cmp_out[0], 1'b0);
    set_cmp(0, 16'd6);
    run(3);
    chk("R8 second event same period", cmp_out[0], 1'b1);
    chk("R12 count held then advanced", count, 16'd7);
  endtask

  task automatic t_wrap();
    do_reset();
    run(65535);
    chk("R12 reaches FFFF", count, 16'hFFFF);
    run(1);
    chk("R12 wraps", count, 16'h0);
    repeat (3) @(negedge clk);
    chk("R12 holds when disabled", count, 16'h0);
  endtask

  initial begin
    #(20 * 190000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_clear_no_irq();
    t_toggle_ctc();
    t_disabled();
    t_shadow();
    t_flag_clear();
    t_multi_ctc();
    t_rewrite();
    t_wrap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule